// File: doc/BRIEF.md
# Register-Mediated Atomic Memory Unit

This unit lets a processor run atomic read-modify-write operations on memory without waiting for the result. It holds a file of wide extended registers, and each one has a full/empty flag. The processor first stores the operands into extended registers. It then launches an operation with a single store to the I/O half of its address space. The address of that store carries both the command and the destination register number, and the store data carries the memory word address. The unit marks the destination empty, reads the memory word, and writes the modified word back where the command calls for it. The old word then goes into the destination register, which becomes full again.

The processor collects a result by loading the destination register. A load of an empty register is held off on the request handshake until the register fills. Requests and load responses both use valid/ready. A request transfers when `req_valid` and `req_ready` are both high on a rising edge, and the request fields must stay stable while `req_ready` is low. A response stays on `rsp_valid`/`rsp_data`, unchanged, until `rsp_ready` takes it. No further load is accepted while an untaken response is pending. The memory port is plain and synchronous: a read issued in one cycle returns its data on `mem_rdata` in the next cycle.

Address map of `req_addr` (14 bits by default):
- Bit 13 selects the space. 0 means register space and 1 means trigger space.
- Bits 12:10 carry the command.
- Bits 9:0 carry the register index.

Indices 0 to 511 are the user registers and 512 to 639 are the system registers.

Command codes: 0 fetch-and-increment, 1 fetch-and-add, 2 compare-and-swap, 3 masked swap.

Top module: `atomic_mem_unit`

## Requirements
- R1: After reset every extended register is empty. A load of a register that has not been written since reset keeps `req_ready` low.
- R2: A store with bit 13 = 0 writes `req_wdata` into register `req_addr[9:0]` and marks it full. A load (`req_write` = 0) of a full register, in either space, returns its contents on `rsp_data`. A store to an index of 640 or more is dropped, and a load of such an index returns zero.
- R3: A store with bit 13 = 1 and a supported command launches one operation on the memory word at `req_wdata[7:0]`. The destination register is empty from acceptance until completion, and then holds the old memory word and is full. The memory read is issued in the cycle after acceptance.
- R4: Command 0 writes old+1 back to memory, wrapping to zero from all ones.
- R5: Command 1 writes old+A back to memory, modulo 2^64, where A is the register after the destination.
- R6: Command 2 compares the old word with A. On a match it writes B to memory, where B is the register two after the destination. On a mismatch memory is left unchanged. In both cases the old word is returned.
- R7: Command 3 writes (old AND NOT A) OR (B AND A) to memory, so only the bits set in the mask A are replaced.
- R8: Operand register numbers wrap past 639 back to 0.
- R9: Only one read-modify-write is in flight. A memory write comes only in the cycle right after a read, no two reads are back to back, and a trigger store sees `req_ready` low while an operation runs.
- R10: A load of a destination whose operation is still running holds `req_ready` low until the old word has arrived.
- R11: A trigger store with command 4 to 7, or with a destination of 640 or more, is accepted. It makes no memory access and leaves the register contents and flags unchanged.
- R12: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` holds steady and a further load sees `req_ready` low.
- R13: During an operation, a store to the in-flight destination is held off, while a store to any other register is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Unit accepts the request |
| req_write | input | 1 | 1 store, 0 load |
| req_addr | input | 14 | Space bit, command, register index |
| req_wdata | input | 64 | Store data; for a trigger, the memory word address |
| rsp_valid | output | 1 | Load response valid |
| rsp_ready | input | 1 | Processor takes the response |
| rsp_data | output | 64 | Loaded register contents |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 write, 0 read (with mem_en) |
| mem_addr | output | 8 | Memory word address |
| mem_wdata | output | 64 | Memory write data |
| mem_rdata | input | 64 | Read data, one cycle after the read |

## Verification
The hardest situation to reach from the ports is the short window in which an operation is in flight. During that window the destination is empty, so loads and stores to it must stall, while stores elsewhere must still go through. The stimulus drives new request fields on the falling edges that immediately follow a trigger's acceptance. It then checks `req_ready` combinationally for each kind of request before the next rising edge, and finally confirms the returned word and the neighbouring register by loads. A second hard case is wrap-around of operand numbers at the top of the system register range. Table vectors place destinations at 638 and 639, with operands stored at registers 0 and 1.

// File: rtl/amu_pkg.sv
package amu_pkg;

  localparam int AMU_CMD_W = 3;

  typedef enum logic [AMU_CMD_W-1:0] {
    CMD_FINC = 3'd0,
    CMD_FADD = 3'd1,
    CMD_CAS  = 3'd2,
    CMD_MSWP = 3'd3
  } amu_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_READ   = 2'd1,
    ST_MODIFY = 2'd2
  } amu_state_e;

  function automatic logic cmd_supported(input logic [AMU_CMD_W-1:0] c);
    return (c[AMU_CMD_W-1] == 1'b0);
  endfunction

endpackage

// File: rtl/amu_regfile.sv
module amu_regfile #(
  parameter int DATA_W = 64,
  parameter int NREGS  = 640,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  // processor store port
  input  logic              pw_en,
  input  logic [IDX_W-1:0]  pw_idx,
  input  logic [DATA_W-1:0] pw_data,
  // result port from the controller
  input  logic              rw_en,
  input  logic [IDX_W-1:0]  rw_idx,
  input  logic [DATA_W-1:0] rw_data,
  // empty marking at launch
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  // read ports
  input  logic [IDX_W-1:0]  ld_idx,
  output logic [DATA_W-1:0] ld_data,
  output logic              ld_full,
  input  logic [IDX_W-1:0]  opa_idx,
  output logic [DATA_W-1:0] opa_data,
  input  logic [IDX_W-1:0]  opb_idx,
  output logic [DATA_W-1:0] opb_data
);

  logic [DATA_W-1:0] regs_q [NREGS];
  logic [NREGS-1:0]  full_q;

  always_ff @(posedge clk) begin
    if (pw_en) regs_q[pw_idx] <= pw_data;
    if (rw_en) regs_q[rw_idx] <= rw_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= '0;
    end else begin
      if (clr_en) full_q[clr_idx] <= 1'b0;
      if (pw_en)  full_q[pw_idx]  <= 1'b1;
      if (rw_en)  full_q[rw_idx]  <= 1'b1;
    end
  end

  assign ld_data  = regs_q[ld_idx];
  assign ld_full  = full_q[ld_idx];
  assign opa_data = regs_q[opa_idx];
  assign opb_data = regs_q[opb_idx];

endmodule

// File: rtl/amu_alu.sv
module amu_alu
  import amu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [AMU_CMD_W-1:0] cmd,
  input  logic [DATA_W-1:0]    old_word,
  input  logic [DATA_W-1:0]    opa,
  input  logic [DATA_W-1:0]    opb,
  output logic [DATA_W-1:0]    new_word,
  output logic                 do_write
);

  always_comb begin
    new_word = old_word;
    do_write = 1'b0;
    case (amu_cmd_e'(cmd))
      CMD_FINC: begin
        new_word = old_word + DATA_W'(1);
        do_write = 1'b1;
      end
      CMD_FADD: begin
        new_word = old_word + opa;
        do_write = 1'b1;
      end
      CMD_CAS: begin
        new_word = opb;
        do_write = (old_word == opa);
      end
      CMD_MSWP: begin
        new_word = (old_word & ~opa) | (opb & opa);
        do_write = 1'b1;
      end
      default: begin
        new_word = old_word;
        do_write = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/amu_ctrl.sv
module amu_ctrl
  import amu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 10,
  parameter int MEM_AW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 launch,
  input  logic [AMU_CMD_W-1:0] launch_cmd,
  input  logic [IDX_W-1:0]     launch_dest,
  input  logic [MEM_AW-1:0]    launch_maddr,
  input  logic [DATA_W-1:0]    launch_opa,
  input  logic [DATA_W-1:0]    launch_opb,
  output logic                 busy,
  output logic [IDX_W-1:0]     cur_dest,
  output logic                 res_en,
  output logic [IDX_W-1:0]     res_idx,
  output logic [DATA_W-1:0]    res_data,
  output logic                 mem_en,
  output logic                 mem_we,
  output logic [MEM_AW-1:0]    mem_addr,
  output logic [DATA_W-1:0]    mem_wdata,
  input  logic [DATA_W-1:0]    mem_rdata
);

  amu_state_e           state_q;
  logic [AMU_CMD_W-1:0] cmd_q;
  logic [IDX_W-1:0]     dest_q;
  logic [MEM_AW-1:0]    maddr_q;
  logic [DATA_W-1:0]    opa_q;
  logic [DATA_W-1:0]    opb_q;
  logic [DATA_W-1:0]    new_word;
  logic                 do_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:   if (launch) state_q <= ST_READ;
        ST_READ:   state_q <= ST_MODIFY;
        ST_MODIFY: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  // operand capture: the launch-time copy keeps later stores from racing in
  always_ff @(posedge clk) begin
    if (state_q == ST_IDLE && launch) begin
      cmd_q   <= launch_cmd;
      dest_q  <= launch_dest;
      maddr_q <= launch_maddr;
      opa_q   <= launch_opa;
      opb_q   <= launch_opb;
    end
  end

  amu_alu #(.DATA_W(DATA_W)) u_alu (
    .cmd      (cmd_q),
    .old_word (mem_rdata),
    .opa      (opa_q),
    .opb      (opb_q),
    .new_word (new_word),
    .do_write (do_write)
  );

  always_comb begin
    busy      = (state_q != ST_IDLE);
    cur_dest  = dest_q;
    res_en    = (state_q == ST_MODIFY);
    res_idx   = dest_q;
    res_data  = mem_rdata;
    mem_en    = (state_q == ST_READ) || (state_q == ST_MODIFY && do_write);
    mem_we    = (state_q == ST_MODIFY) && do_write;
    mem_addr  = maddr_q;
    mem_wdata = new_word;
  end

endmodule

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit
  import amu_pkg::*;
#(
  parameter  int DATA_W    = 64,
  parameter  int USER_REGS = 512,
  parameter  int SYS_REGS  = 128,
  parameter  int MEM_AW    = 8,
  localparam int NREGS     = USER_REGS + SYS_REGS,
  localparam int IDX_W     = $clog2(NREGS),
  localparam int ADDR_W    = 1 + AMU_CMD_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_en,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam logic [IDX_W:0] NREGS_L = (IDX_W+1)'(NREGS);

  // request decode
  logic                 is_trig;
  logic [AMU_CMD_W-1:0] req_cmd;
  logic [IDX_W-1:0]     req_idx;
  logic                 idx_ok;

  assign is_trig = req_addr[ADDR_W-1];
  assign req_cmd = req_addr[IDX_W +: AMU_CMD_W];
  assign req_idx = req_addr[IDX_W-1:0];
  assign idx_ok  = ({1'b0, req_idx} < NREGS_L);

  // operand numbers, wrapping past the last register
  logic [IDX_W:0]   sum_a, sum_b, wrap_a, wrap_b;
  logic [IDX_W-1:0] opa_idx, opb_idx;

  always_comb begin
    sum_a   = {1'b0, req_idx} + (IDX_W+1)'(1);
    sum_b   = {1'b0, req_idx} + (IDX_W+1)'(2);
    wrap_a  = (sum_a >= NREGS_L) ? sum_a - NREGS_L : sum_a;
    wrap_b  = (sum_b >= NREGS_L) ? sum_b - NREGS_L : sum_b;
    opa_idx = wrap_a[IDX_W-1:0];
    opb_idx = wrap_b[IDX_W-1:0];
  end

  logic              busy;
  logic [IDX_W-1:0]  cur_dest;
  logic              res_en;
  logic [IDX_W-1:0]  res_idx;
  logic [DATA_W-1:0] res_data;
  logic [DATA_W-1:0] ld_data, opa_data, opb_data;
  logic              ld_full;
  logic              rsp_free;
  logic              fire;
  logic              store_fire, load_fire, launch;

  assign rsp_free = !rsp_valid || rsp_ready;

  always_comb begin
    if (!req_write)
      req_ready = rsp_free && (!idx_ok || ld_full);
    else if (is_trig)
      req_ready = !busy;
    else
      req_ready = !(busy && req_idx == cur_dest);
  end

  assign fire       = req_valid && req_ready;
  assign load_fire  = fire && !req_write;
  assign store_fire = fire && req_write && !is_trig && idx_ok;
  assign launch     = fire && req_write && is_trig && idx_ok && cmd_supported(req_cmd);

  amu_regfile #(.DATA_W(DATA_W), .NREGS(NREGS), .IDX_W(IDX_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .pw_en    (store_fire),
    .pw_idx   (req_idx),
    .pw_data  (req_wdata),
    .rw_en    (res_en),
    .rw_idx   (res_idx),
    .rw_data  (res_data),
    .clr_en   (launch),
    .clr_idx  (req_idx),
    .ld_idx   (req_idx),
    .ld_data  (ld_data),
    .ld_full  (ld_full),
    .opa_idx  (opa_idx),
    .opa_data (opa_data),
    .opb_idx  (opb_idx),
    .opb_data (opb_data)
  );

  amu_ctrl #(.DATA_W(DATA_W), .IDX_W(IDX_W), .MEM_AW(MEM_AW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch       (launch),
    .launch_cmd   (req_cmd),
    .launch_dest  (req_idx),
    .launch_maddr (req_wdata[MEM_AW-1:0]),
    .launch_opa   (opa_data),
    .launch_opb   (opb_data),
    .busy         (busy),
    .cur_dest     (cur_dest),
    .res_en       (res_en),
    .res_idx      (res_idx),
    .res_data     (res_data),
    .mem_en       (mem_en),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_rdata    (mem_rdata)
  );

  // load response holding register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (load_fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= idx_ok ? ld_data : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/amu_checker.sv
module amu_checker #(
  parameter int DATA_W = 64,
  parameter int NREGS  = 640,
  parameter int IDX_W  = 10,
  parameter int ADDR_W = 14,
  parameter int MEM_AW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [MEM_AW-1:0] trig_maddr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              mem_en,
  input logic              mem_we,
  input logic [MEM_AW-1:0] mem_addr
);

  logic trig_fire, trig_good, trig_bad, mem_rd, mem_wr;

  assign trig_fire = req_valid && req_ready && req_write && req_addr[ADDR_W-1];
  assign trig_good = trig_fire && (req_addr[ADDR_W-2] == 1'b0) &&
                     (int'(req_addr[IDX_W-1:0]) < NREGS);
  assign trig_bad  = trig_fire && !trig_good;
  assign mem_rd    = mem_en && !mem_we;
  assign mem_wr    = mem_en && mem_we;

  assert_trigger_reads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trig_good |=> mem_rd && mem_addr == $past(trig_maddr));

  assert_write_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd));

  assert_no_back_to_back_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  assert_no_trigger_in_flight_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !trig_fire);

  assert_bad_trigger_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    trig_bad |=> !mem_en);

  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

endmodule

bind atomic_mem_unit amu_checker #(
  .DATA_W(DATA_W), .NREGS(NREGS), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .MEM_AW(MEM_AW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .trig_maddr (req_wdata[MEM_AW-1:0]),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_data   (rsp_data),
  .mem_en     (mem_en),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr)
);

// File: tb/atomic_mem_unit_tb.sv
module atomic_mem_unit_tb;

  localparam int DW = 64;
  localparam int NR = 640;
  localparam int AW = 14;
  localparam int MA = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid, mem_en, mem_we;
  logic [DW-1:0] rsp_data, mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [MA-1:0] mem_addr;

  int n_chk = 0, n_fail = 0, mem_ops = 0;

  always #4 clk = ~clk;

  atomic_mem_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model with a bench-side preload port
  logic [DW-1:0] bmem [256];
  logic          poke_en = 1'b0;
  logic [MA-1:0] poke_addr = '0;
  logic [DW-1:0] poke_data = '0;

  always @(posedge clk) begin
    if (poke_en) bmem[poke_addr] <= poke_data;
    if (mem_en) begin
      mem_ops <= mem_ops + 1;
      if (mem_we) bmem[mem_addr] <= mem_wdata;
      else        mem_rdata <= bmem[mem_addr];
    end
  end

  typedef struct packed {
    logic [2:0]  cmd;
    logic [9:0]  dest;
    logic [7:0]  maddr;
    logic [63:0] init;
    logic [63:0] opa;
    logic [63:0] opb;
    logic [63:0] exp_old;
    logic [63:0] exp_mem;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 10'd10,  8'd3,  64'h41, 64'h0, 64'h0, 64'h41, 64'h42},
    '{3'd0, 10'd20,  8'd4,  64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0,
      64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
    '{3'd1, 10'd30,  8'd5,  64'd100, 64'd23, 64'h0, 64'd100, 64'd123},
    '{3'd1, 10'd40,  8'd6,  64'd5, 64'hFFFF_FFFF_FFFF_FFFE, 64'h0, 64'd5, 64'd3},
    '{3'd2, 10'd50,  8'd7,  64'hAA, 64'hAA, 64'h55, 64'hAA, 64'h55},
    '{3'd2, 10'd60,  8'd8,  64'hAB, 64'hAA, 64'h55, 64'hAB, 64'hAB},
    '{3'd3, 10'd70,  8'd9,  64'h1234_5678, 64'h0000_FF00, 64'hABCD_EF99,
      64'h1234_5678, 64'h1234_EF78},
    '{3'd3, 10'd600, 8'd10, 64'hF0F0_F0F0_F0F0_F0F0, 64'h0000_0000_FFFF_FFFF,
      64'h0123_4567_89AB_CDEF, 64'hF0F0_F0F0_F0F0_F0F0, 64'hF0F0_F0F0_89AB_CDEF},
    '{3'd1, 10'd639, 8'd11, 64'd1000, 64'd7, 64'h0, 64'd1000, 64'd1007},
    '{3'd2, 10'd638, 8'd12, 64'd9, 64'd9, 64'd77, 64'd9, 64'd77}
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [MA-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_addr = a; poke_data = d;
    @(posedge clk);
    #1 poke_en = 1'b0;
  endtask

  task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic do_load(input logic [9:0] idx, output logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = {4'b0, idx};
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_data;
  endtask

  function automatic logic [9:0] wrapi(input int i);
    return 10'(i % NR);
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [DW-1:0] d;
    int ops0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    check("R1 rsp_valid after reset", {63'b0, rsp_valid}, 64'd0);
    check("R1 mem_en after reset", {63'b0, mem_en}, 64'd0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 14'd5;
    for (int i = 0; i < 4; i++) begin
      #1 check("R1 load of unwritten register stalls", {63'b0, req_ready}, 64'd0);
      @(negedge clk);
    end
    req_valid = 1'b0;

    // R2: plain store and load
    do_store(14'd5, 64'hCAFE_0000_0000_0005);
    do_load(10'd5, d);
    check("R2 load returns stored word", d, 64'hCAFE_0000_0000_0005);
    do_store(14'd700, 64'h1);
    do_load(10'd700, d);
    check("R2 out-of-range load returns zero", d, 64'h0);

    // table of operations: R3..R8
    for (int v = 0; v < NV; v++) begin
      poke(VECS[v].maddr, VECS[v].init);
      do_store({4'b0, wrapi(int'(VECS[v].dest) + 1)}, VECS[v].opa);
      do_store({4'b0, wrapi(int'(VECS[v].dest) + 2)}, VECS[v].opb);
      do_store({1'b1, VECS[v].cmd, VECS[v].dest}, {56'b0, VECS[v].maddr});
      do_load(VECS[v].dest, d);
      check($sformatf("R3 old word vector %0d", v), d, VECS[v].exp_old);
      repeat (2) @(posedge clk);
      case (VECS[v].cmd)
        3'd0: check($sformatf("R4 memory vector %0d", v), bmem[VECS[v].maddr], VECS[v].exp_mem);
        3'd1: check($sformatf("R5 R8 memory vector %0d", v), bmem[VECS[v].maddr], VECS[v].exp_mem);
        3'd2: check($sformatf("R6 R8 memory vector %0d", v), bmem[VECS[v].maddr], VECS[v].exp_mem);
        default: check($sformatf("R7 memory vector %0d", v), bmem[VECS[v].maddr], VECS[v].exp_mem);
      endcase
    end

    // R10, R13, R9: requests while an operation is in flight
    poke(8'd20, 64'd7);
    do_store(14'd101, 64'h0);
    do_store({1'b1, 3'd0, 10'd100}, 64'd20);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 14'd100;
    #1 check("R10 load of in-flight destination stalls", {63'b0, req_ready}, 64'd0);
    req_write = 1'b1; req_wdata = 64'hBAD;
    #1 check("R13 store to in-flight destination stalls", {63'b0, req_ready}, 64'd0);
    req_addr = 14'd101; req_wdata = 64'h1010;
    #1 check("R13 store to other register accepted", {63'b0, req_ready}, 64'd1);
    @(posedge clk);
    @(negedge clk);
    req_addr = {1'b1, 3'd0, 10'd120}; req_wdata = 64'd21;
    #1 check("R9 trigger stalls while busy", {63'b0, req_ready}, 64'd0);
    req_valid = 1'b0;
    do_load(10'd100, d);
    check("R10 old word after stall", d, 64'd7);
    do_load(10'd101, d);
    check("R13 neighbour store landed", d, 64'h1010);
    check("R4 in-flight increment memory", bmem[20], 64'd8);

    // R11: unsupported command and out-of-range destination
    poke(8'd30, 64'd5);
    do_store(14'd200, 64'hDEAD);
    ops0 = mem_ops;
    do_store({1'b1, 3'd5, 10'd200}, 64'd30);
    do_store({1'b1, 3'd1, 10'd900}, 64'd30);
    repeat (4) @(posedge clk);
    check("R11 no memory access", 64'(mem_ops - ops0), 64'd0);
    do_load(10'd200, d);
    check("R11 register unchanged and full", d, 64'hDEAD);
    check("R11 memory unchanged", bmem[30], 64'd5);

    // R12: response back-pressure
    do_store(14'd300, 64'h11);
    do_store(14'd301, 64'h22);
    rsp_ready = 1'b0;
    do_load(10'd300, d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 14'd301;
    for (int i = 0; i < 3; i++) begin
      #1 check("R12 second load held", {63'b0, req_ready}, 64'd0);
      check("R12 response held", rsp_data, 64'h11);
      check("R12 response valid held", {63'b0, rsp_valid}, 64'd1);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R12 second load after release", rsp_data, 64'h22);

    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule